// File: doc/BRIEF.md
# Bidirectional Digital Pin Bank

This block controls a group of bidirectional digital lines. Each line keeps its own output-data bit and output-enable bit. Each pad is modelled as three wires: an enable, a driven level and an input sample. Internal logic writes the lines through two command channels that are independent of each other. The data channel loads output data. The data channel can optionally turn the driver on in the same write. The enable channel only switches drivers on or off. Either channel can address the whole port word or a single line. A single-line command takes its value from bit 0 of the value bus. A whole-word command maps bit i of the value bus to line i, with bit 0 being the least significant bit.

Because data and enable are held separately, the level a line will drive can be staged while the line is still an input, and it appears on the pad only once the enable is set. A line that has been driven must have its enable cleared before it can be used as an input again. Reads return the level seen at each pin. For an undriven line that is the pad input after a two-flop synchroniser. For a driven line it is the value the bank itself drives. The packed read word and a single-bit read selected by index are both available.

Top module: `bidir_pin_bank`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, all output enables and all output data bits clear to 0 from that edge on, so every line starts as an input.
- R2: A data-channel write with dat_drive=1 loads the output data and sets the output enable of every addressed line. In word scope (dat_single=0) that is all lines, and pad_do equals dat_val after the next clock edge.
- R3: A data-channel write with dat_drive=0 updates only the output data. pad_oe is unchanged after that edge.
- R4: An enable-channel write sets pad_oe of the addressed lines to the given value (oe_val bit i for line i in word scope) and leaves pad_do unchanged.
- R5: In single-line scope (dat_single=1 or oe_single=1) only the line numbered dat_line or oe_line changes. It takes bit 0 of the value bus, and every other line keeps its data and enable.
- R6: When a data-only write and an enable write to the same lines arrive in the same cycle, both take effect at that edge, so the first value driven is the new data.
- R7: When a driving data write and an enable write address the same line in the same cycle, the enable channel's value decides that line's output enable.
- R8: For a line whose enable is 0, rd_word bit i equals pad_in bit i as sampled two clock edges earlier.
- R9: For a line whose enable is 1, rd_word bit i equals pad_do bit i, whatever pad_in is.
- R10: rd_bit equals bit rd_sel of rd_word, with index 0 being the least significant bit. An index of W or more reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_we | input | 1 | Data-channel write strobe |
| dat_single | input | 1 | Data channel scope: 1 = one line, 0 = whole word |
| dat_drive | input | 1 | 1 = the data write also turns on the addressed drivers |
| dat_line | input | IDX_W | Line index for a single-line data write |
| dat_val | input | W | Data value (bit 0 used in single-line scope) |
| oe_we | input | 1 | Enable-channel write strobe |
| oe_single | input | 1 | Enable channel scope: 1 = one line, 0 = whole word |
| oe_line | input | IDX_W | Line index for a single-line enable write |
| oe_val | input | W | Enable value (bit 0 used in single-line scope) |
| pad_in | input | W | Level sampled at each pad |
| pad_do | output | W | Level each pad drives when enabled |
| pad_oe | output | W | Per-line driver enable |
| rd_sel | input | IDX_W | Line index for the single-bit read |
| rd_word | output | W | Packed read of all line levels |
| rd_bit | output | 1 | Level of line rd_sel |

## Verification
A wrong data or enable bit shows on pad_do or pad_oe one edge after the command that set it. It shows again on rd_word, because a driven line reads back its own data, while an undriven line exposes the synchroniser instead. A synchroniser with the wrong depth shows as rd_word following a pad_in change one edge early or late. A wrong precedence between the two channels shows only in cycles where both address the same line. The bench therefore drives such collisions deliberately as well as in a long pseudo-random stretch, and compares every port against a behavioural model on every cycle.

// File: rtl/bidir_pin_pkg.sv
// Shared definitions for the bidirectional pin bank.
// Assumes: none beyond IEEE 1800-2017.
package bidir_pin_pkg;

    // Command scope: the whole port word or one addressed line.
    typedef enum logic {
        SCOPE_WORD = 1'b0,
        SCOPE_LINE = 1'b1
    } scope_e;

    // Index width for a port of the given width (at least one bit).
    function automatic int unsigned idx_width(input int unsigned w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/bidir_line_regs.sv
// Per-line output-data and output-enable storage.
// Each line decodes both command channels on its own. The enable channel
// has priority over the implicit enable of a driving data write.
// Assumes: synchronous active-low reset; commands are stable at the edge.
module bidir_line_regs
    import bidir_pin_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = idx_width(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_we,
    input  logic             dat_single,
    input  logic             dat_drive,
    input  logic [IDX_W-1:0] dat_line,
    input  logic [W-1:0]     dat_val,
    input  logic             oe_we,
    input  logic             oe_single,
    input  logic [IDX_W-1:0] oe_line,
    input  logic [W-1:0]     oe_val,
    output logic [W-1:0]     q_do,
    output logic [W-1:0]     q_oe
);

    scope_e dat_scope;
    scope_e oe_scope;

    // Map the raw scope inputs onto the shared enum.
    always_comb begin
        dat_scope = dat_single ? SCOPE_LINE : SCOPE_WORD;
        oe_scope  = oe_single  ? SCOPE_LINE : SCOPE_WORD;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic hit_d;
        logic hit_e;
        logic nxt_d;
        logic nxt_e;

        // Decide whether this line is addressed and which value bit it takes.
        always_comb begin
            hit_d = dat_we && ((dat_scope == SCOPE_WORD) || (dat_line == IDX_W'(i)));
            hit_e = oe_we  && ((oe_scope  == SCOPE_WORD) || (oe_line  == IDX_W'(i)));
            nxt_d = (dat_scope == SCOPE_LINE) ? dat_val[0] : dat_val[i];
            nxt_e = (oe_scope  == SCOPE_LINE) ? oe_val[0]  : oe_val[i];
        end

        // Hold this line's data and enable; the explicit enable wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_do[i] <= 1'b0;
                q_oe[i] <= 1'b0;
            end else begin
                if (hit_d) begin
                    q_do[i] <= nxt_d;
                end
                if (hit_e) begin
                    q_oe[i] <= nxt_e;
                end else if (hit_d && dat_drive) begin
                    q_oe[i] <= 1'b1;
                end
            end
        end
    end

    // R1: reset clears every enable and data bit.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (q_oe == '0) && (q_do == '0));

    // R3: a data-only write with no enable command leaves the enables alone.
    p_dataonly_keeps_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !dat_drive && !oe_we) |=> $stable(q_oe));

    // R4: an enable command without a data write leaves the data alone.
    p_enable_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_we && !dat_we) |=> $stable(q_do));

    // R2: a driving word write turns on every driver and loads the word.
    p_drive_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && dat_drive && !dat_single && !oe_we)
        |=> (q_oe == '1) && (q_do == $past(dat_val)));

    // R7: a word enable command decides the enables even against a driving write.
    p_enable_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_we && !oe_single) |=> (q_oe == $past(oe_val)));

endmodule

// File: rtl/bidir_in_sync.sv
// Two-flop synchroniser for the pad input samples.
// Assumes: pad_in may be asynchronous; reset is synchronous active-low.
module bidir_in_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;

    // Shift the pad levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

    // R8: the output is the input from exactly two edges back.
    p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (q_sync == $past(d_async, 2)));

endmodule

// File: rtl/bidir_read_mux.sv
// Read path: a driven line reads its own output data, an undriven line
// reads its synchronised pad level; plus an indexed single-bit read.
// Assumes: an index of W or more reads as 0.
module bidir_read_mux
    import bidir_pin_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = idx_width(W)
) (
    input  logic [W-1:0]     q_do,
    input  logic [W-1:0]     q_oe,
    input  logic [W-1:0]     q_sync,
    input  logic [IDX_W-1:0] sel,
    output logic [W-1:0]     word,
    output logic             bit_out
);

    for (genvar i = 0; i < W; i++) begin : g_pick
        // Choose the level this line reports.
        always_comb begin
            word[i] = q_oe[i] ? q_do[i] : q_sync[i];
        end
    end

    // Select one line of the packed word by index.
    always_comb begin
        bit_out = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (sel == IDX_W'(k)) begin
                bit_out = word[k];
            end
        end
    end

    // R9: every enabled line reads back exactly what it drives.
    always_comb begin
        p_driven_readback_r9: assert ((word & q_oe) == (q_do & q_oe));
    end

endmodule

// File: rtl/bidir_pin_bank.sv
// Bidirectional pin bank top: per-line data/enable storage, input
// synchroniser and read path.
// Assumes: W is 8, 16 or 32 in normal use; pads are modelled as
// enable + data outputs with a separate input sample.
module bidir_pin_bank
    import bidir_pin_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = idx_width(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_we,
    input  logic             dat_single,
    input  logic             dat_drive,
    input  logic [IDX_W-1:0] dat_line,
    input  logic [W-1:0]     dat_val,
    input  logic             oe_we,
    input  logic             oe_single,
    input  logic [IDX_W-1:0] oe_line,
    input  logic [W-1:0]     oe_val,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_do,
    output logic [W-1:0]     pad_oe,
    input  logic [IDX_W-1:0] rd_sel,
    output logic [W-1:0]     rd_word,
    output logic             rd_bit
);

    logic [W-1:0] q_sync;

    bidir_line_regs #(.W(W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat_we     (dat_we),
        .dat_single (dat_single),
        .dat_drive  (dat_drive),
        .dat_line   (dat_line),
        .dat_val    (dat_val),
        .oe_we      (oe_we),
        .oe_single  (oe_single),
        .oe_line    (oe_line),
        .oe_val     (oe_val),
        .q_do       (pad_do),
        .q_oe       (pad_oe)
    );

    bidir_in_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (q_sync)
    );

    bidir_read_mux #(.W(W), .IDX_W(IDX_W)) u_read (
        .q_do    (pad_do),
        .q_oe    (pad_oe),
        .q_sync  (q_sync),
        .sel     (rd_sel),
        .word    (rd_word),
        .bit_out (rd_bit)
    );

endmodule

// File: tb/sim_bidir_pin_bank.sv
// Bench for bidir_pin_bank: a behavioural model updated on every clock
// and compared 5 ns after each edge, plus directed literal checks.
module sim_bidir_pin_bank;

    localparam int W  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dat_we = 1'b0, dat_single = 1'b0, dat_drive = 1'b0;
    logic [IW-1:0] dat_line = '0;
    logic [W-1:0]  dat_val = '0;
    logic          oe_we = 1'b0, oe_single = 1'b0;
    logic [IW-1:0] oe_line = '0;
    logic [W-1:0]  oe_val = '0;
    logic [W-1:0]  pad_in = '0;
    logic [IW-1:0] rd_sel = '0;
    logic [W-1:0]  pad_do, pad_oe, rd_word;
    logic          rd_bit;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    bidir_pin_bank #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dat_we(dat_we), .dat_single(dat_single), .dat_drive(dat_drive),
        .dat_line(dat_line), .dat_val(dat_val),
        .oe_we(oe_we), .oe_single(oe_single), .oe_line(oe_line), .oe_val(oe_val),
        .pad_in(pad_in), .pad_do(pad_do), .pad_oe(pad_oe),
        .rd_sel(rd_sel), .rd_word(rd_word), .rd_bit(rd_bit)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model state.
    logic [W-1:0] m_do = '0, m_oe = '0, m_s1 = '0, m_s2 = '0;

    always @(posedge clk) begin
        logic [W-1:0] ew;
        if (!rst_n) begin
            m_do = '0; m_oe = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            for (int l = 0; l < W; l++) begin
                if (dat_we && (!dat_single || dat_line == l)) begin
                    m_do[l] = dat_single ? dat_val[0] : dat_val[l];
                    if (dat_drive) m_oe[l] = 1'b1;
                end
            end
            for (int l = 0; l < W; l++) begin
                if (oe_we && (!oe_single || oe_line == l))
                    m_oe[l] = oe_single ? oe_val[0] : oe_val[l];
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
        #5;
        ew = (m_oe & m_do) | (~m_oe & m_s2);
        check({cur_req, " pad_oe"}, 32'(pad_oe), 32'(m_oe));
        check({cur_req, " pad_do"}, 32'(pad_do), 32'(m_do));
        check({cur_req, " rd_word"}, 32'(rd_word), 32'(ew));
        check({cur_req, " rd_bit (R10)"}, 32'(rd_bit), 32'(ew[rd_sel]));
    end

    task automatic idle();
        dat_we = 1'b0; oe_we = 1'b0;
    endtask

    // Drive at a falling edge, then wait until 5 ns after the next rising edge.
    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic go();
        @(negedge clk);
    endtask

    logic [31:0] lfsr = 32'h1D2C_3B4A;

    initial begin
        go(); go(); go();
        check("R1 reset oe", 32'(pad_oe), 32'h00);
        check("R1 reset do", 32'(pad_do), 32'h00);
        go(); rst_n = 1'b1;

        cur_req = "R2";
        go(); dat_we = 1; dat_single = 0; dat_drive = 1; dat_val = 8'hA5;
        step(); check("R2 oe", 32'(pad_oe), 32'hFF); check("R2 do", 32'(pad_do), 32'hA5);

        cur_req = "R3";
        go(); dat_drive = 0; dat_val = 8'h3C;
        step(); check("R3 oe", 32'(pad_oe), 32'hFF); check("R3 do", 32'(pad_do), 32'h3C);

        cur_req = "R4";
        go(); idle(); oe_we = 1; oe_single = 0; oe_val = 8'h00; pad_in = 8'h96;
        step(); check("R4 oe", 32'(pad_oe), 32'h00); check("R4 do", 32'(pad_do), 32'h3C);

        cur_req = "R8";
        go(); idle();
        step(); check("R8 two edges", 32'(rd_word), 32'h96);

        cur_req = "R5";
        go(); dat_we = 1; dat_single = 1; dat_drive = 0; dat_line = 3'd6; dat_val = 8'h01;
        step(); check("R5 do", 32'(pad_do), 32'h7C); check("R5 oe", 32'(pad_oe), 32'h00);

        cur_req = "R9";
        go(); idle(); oe_we = 1; oe_single = 1; oe_line = 3'd6; oe_val = 8'h01; rd_sel = 3'd6;
        step(); check("R5 single oe", 32'(pad_oe), 32'h40);
        check("R9 driven read", 32'(rd_word), 32'hD6);
        check("R10 bit6", 32'(rd_bit), 32'h1);
        go(); idle(); rd_sel = 3'd0; pad_in = 8'h00;
        step(); check("R10 bit0", 32'(rd_bit), 32'h0);
        step(); step(); check("R9 ignores pad_in", 32'(rd_word), 32'h40);

        cur_req = "R6";
        go(); dat_we = 1; dat_single = 0; dat_drive = 0; dat_val = 8'h01;
        oe_we = 1; oe_single = 0; oe_val = 8'hFF;
        step(); check("R6 oe", 32'(pad_oe), 32'hFF); check("R6 do", 32'(pad_do), 32'h01);
        check("R6 read", 32'(rd_word), 32'h01);

        cur_req = "R7";
        go(); dat_drive = 1; dat_val = 8'hF0; oe_val = 8'h00;
        step(); check("R7 word oe", 32'(pad_oe), 32'h00); check("R7 word do", 32'(pad_do), 32'hF0);
        go(); dat_single = 1; dat_line = 3'd3; dat_val = 8'h01;
        oe_single = 1; oe_line = 3'd3; oe_val = 8'h00;
        step(); check("R7 line oe", 32'(pad_oe), 32'h00); check("R7 line do", 32'(pad_do), 32'hF8);

        cur_req = "R5 random";
        for (int c = 0; c < 400; c++) begin
            go();
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            dat_we = lfsr[0]; dat_single = lfsr[1]; dat_drive = lfsr[2];
            dat_line = lfsr[5:3]; dat_val = lfsr[13:6];
            oe_we = lfsr[14] & lfsr[15]; oe_single = lfsr[16]; oe_line = lfsr[19:17];
            oe_val = lfsr[27:20]; rd_sel = lfsr[30:28];
            if (lfsr[31]) pad_in = lfsr[24:17];
        end
        cur_req = "R1 again";
        go(); idle(); rst_n = 1'b0;
        step(); check("R1 mid reset oe", 32'(pad_oe), 32'h00);
        check("R1 mid reset do", 32'(pad_do), 32'h00);
        go();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule